// File: doc/BRIEF.md
# Debug Vector Catch and Event Cause Recorder

This block sits beside a processor core and decides when a fault, a reset or one of the debug event sources must stop the core in its halted debug state. Each class of core exception has its own catch-enable bit in a monitor control register. A caught exception, a halt or single-step request, a breakpoint match, a data watchpoint match or a signal from an external debug probe becomes a debug event. With halting debug enabled, an event raises a one-cycle halt request. With halting debug disabled but the debug monitor enabled, the event instead marks the monitor exception pending, so a software debug handler can service it without stopping the system.

A second register keeps one sticky flag per event class. Debug software reads it to learn why the core stopped, and writes ones to clear the flags it has dealt with. The monitor control register also holds a single-step-through-monitor enable, a semaphore bit for debug software and a global enable for the watchpoint and trace units. These last three only appear on outputs or on readback. The register port uses one select bit: 0 addresses the monitor control register and 1 the event status register.

Top module: `dbg_catch_unit`

## Requirements
- R1: After reset both registers read zero, and halt_req, mon_pend, mon_step_en and trace_en are low.
- R2: A write with wr_sel=0 loads the monitor control register. Only these bits are kept: bit 0 (reset catch), bits 4..10 (fault catches), bit 16 (monitor enable), bit 17 (monitor pending), bit 18 (monitor step), bit 19 (semaphore) and bit 24 (trace enable). All other bits read 0. rd_sel=0 reads it back, rd_sel=1 reads the status register zero-extended.
- R3: exc_strobe[0] is a local reset, and exc_strobe[1..7] are, in order: memory-management fault, coprocessor-access usage fault, checking-error usage fault, state-error usage fault, bus fault, fault on exception entry or return, and hard fault. Strobe bit 0 is enabled by control bit 0, and strobe bit i (i>=1) by control bit i+3. An enabled strobe with halt_en high raises halt_req in the next cycle and sets status bit 3. A strobe whose enable is clear has no effect.
- R4: In the next cycle, halt_step_req, bkpt_hit, wpt_hit and ext_probe set status bits 0, 1, 2 and 4 respectively. Each of them raises halt_req when halt_en is high.
- R5: halt_req is high only in a cycle that follows a cycle with halt_en high.
- R6: If an event occurs while halt_en is low and monitor enable (bit 16) is set, mon_pend (bit 17) is set in the next cycle, no halt is requested, and the cause is recorded.
- R7: If an event occurs while halt_en is low and monitor enable is clear, the status register, halt_req and mon_pend are all left unchanged.
- R8: Status flags are sticky. A write with wr_sel=1 clears every flag whose data bit is 1 and leaves the rest. A flag being set in the same cycle stays set.
- R9: Events in the same cycle set every matching flag.
- R10: Writing bit 17 sets or clears the monitor pending state. An event that sets pending in the same cycle wins over a write of 0.
- R11: mon_step_en follows bit 18 and trace_en follows bit 24. Bit 19 only reads back and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_en | input | 1 | Halting debug enabled by the probe |
| exc_strobe | input | 8 | One-cycle exception-class strobes from the core |
| halt_step_req | input | 1 | Halt or single-step request |
| bkpt_hit | input | 1 | Breakpoint instruction or comparator match |
| wpt_hit | input | 1 | Data watchpoint match |
| ext_probe | input | 1 | External debug request from the probe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status (write-one-to-clear) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | 32 | Read data |
| halt_req | output | 1 | Request to enter halted debug state |
| mon_pend | output | 1 | Monitor exception pending |
| mon_step_en | output | 1 | Stepping through the monitor enabled |
| trace_en | output | 1 | Global watchpoint and trace enable |

## Verification
The bench targets the mapping from each exception strobe to its catch bit. A design that shifts the fault field by one would halt on the wrong fault, or on none. It also targets cycles where a status flag is set and cleared at once, and cycles where an event and a software write both touch the pending bit. A design with the priority reversed would lose a cause or a pending monitor request. Events arrive with halting off and the monitor on, and with both off. These cases expose a design that still halts, sets pending without the monitor, or records causes it should drop. Long random runs mix all inputs and writes against a bench model, to catch flags lost when several events coincide.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  localparam int REG_W   = 32;
  localparam int N_EXC   = 8;
  localparam int N_EVT   = 5;

  // control register field positions
  localparam int CTL_RESET_CATCH = 0;
  localparam int CTL_FAULT_LO    = 4;
  localparam int CTL_MON_EN      = 16;
  localparam int CTL_MON_PEND    = 17;
  localparam int CTL_MON_STEP    = 18;
  localparam int CTL_SEMA        = 19;
  localparam int CTL_TRACE       = 24;

  // status register flag positions
  localparam int EV_HALT   = 0;
  localparam int EV_BKPT   = 1;
  localparam int EV_WPT    = 2;
  localparam int EV_VCATCH = 3;
  localparam int EV_EXT    = 4;

  // control bit that enables catching exception strobe idx
  function automatic int catch_pos(input int idx);
    return (idx == 0) ? CTL_RESET_CATCH : CTL_FAULT_LO + idx - 1;
  endfunction

  // mask of implemented control bits
  function automatic logic [REG_W-1:0] ctl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_EXC; i++) m[catch_pos(i)] = 1'b1;
    m[CTL_MON_EN]   = 1'b1;
    m[CTL_MON_PEND] = 1'b1;
    m[CTL_MON_STEP] = 1'b1;
    m[CTL_SEMA]     = 1'b1;
    m[CTL_TRACE]    = 1'b1;
    return m;
  endfunction

  // an event is recorded when it leads to a halt or a monitor request
  function automatic logic event_taken(input logic halt_on, input logic mon_on);
    return halt_on | mon_on;
  endfunction
endpackage

// File: rtl/dcu_event_decode.sv
module dcu_event_decode
  import dcu_pkg::*;
#(
  parameter int NE = N_EXC,
  parameter int NV = N_EVT
) (
  input  logic [NE-1:0] exc_strobe,
  input  logic [NE-1:0] catch_en,
  input  logic          halt_step_req,
  input  logic          bkpt_hit,
  input  logic          wpt_hit,
  input  logic          ext_probe,
  output logic          catch_hit,
  output logic [NV-1:0] evt_vec,
  output logic          evt_any
);
  logic [NE-1:0] caught;

  for (genvar g = 0; g < NE; g++) begin : g_catch
    assign caught[g] = exc_strobe[g] & catch_en[g];
  end

  assign catch_hit = |caught;

  always_comb begin
    evt_vec            = '0;
    evt_vec[EV_HALT]   = halt_step_req;
    evt_vec[EV_BKPT]   = bkpt_hit;
    evt_vec[EV_WPT]    = wpt_hit;
    evt_vec[EV_VCATCH] = catch_hit;
    evt_vec[EV_EXT]    = ext_probe;
  end

  assign evt_any = |evt_vec;
endmodule

// File: rtl/dcu_ctrl_reg.sv
module dcu_ctrl_reg
  import dcu_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctl,
  input  logic [W-1:0] wr_data,
  input  logic         pend_set,
  output logic [W-1:0] ctl_q
);
  localparam logic [W-1:0] MASK = ctl_mask();
  logic [W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) ctl_d = wr_data & MASK;
    if (pend_set) ctl_d[CTL_MON_PEND] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) pend_set |=> ctl_q[CTL_MON_PEND]); // R10
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!wr_ctl && !pend_set) |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/dcu_status_reg.sv
module dcu_status_reg
  import dcu_pkg::*;
#(
  parameter int NV = N_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] evt_vec,
  input  logic          take,
  input  logic [NV-1:0] clr_vec,
  output logic [NV-1:0] status_q
);
  for (genvar g = 0; g < NV; g++) begin : g_flag
    logic set_now;
    assign set_now = take & evt_vec[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          status_q[g] <= 1'b0;
      else if (set_now)    status_q[g] <= 1'b1;
      else if (clr_vec[g]) status_q[g] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (status_q[g] && !clr_vec[g]) |=> status_q[g]); // R8
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) (take && evt_vec[g]) |=> status_q[g]); // R9
    AST_FLAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (!take && !clr_vec[g]) |=> $stable(status_q[g])); // R7
  end
endmodule

// File: rtl/dbg_catch_unit.sv
module dbg_catch_unit
  import dcu_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NE = N_EXC,
  parameter int NV = N_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_en,
  input  logic [NE-1:0] exc_strobe,
  input  logic          halt_step_req,
  input  logic          bkpt_hit,
  input  logic          wpt_hit,
  input  logic          ext_probe,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_sel,
  output logic [W-1:0]  rd_data,
  output logic          halt_req,
  output logic          mon_pend,
  output logic          mon_step_en,
  output logic          trace_en
);
  logic [W-1:0]  ctl_q;
  logic [NE-1:0] catch_en;
  logic [NV-1:0] evt_vec;
  logic [NV-1:0] status_q;
  logic [NV-1:0] clr_vec;
  logic          catch_hit;
  logic          evt_any;
  logic          mon_on;
  logic          take;
  logic          pend_set;
  logic          halt_set;

  for (genvar g = 0; g < NE; g++) begin : g_en
    assign catch_en[g] = ctl_q[catch_pos(g)];
  end

  dcu_event_decode #(.NE(NE), .NV(NV)) u_dec (
    .exc_strobe   (exc_strobe),
    .catch_en     (catch_en),
    .halt_step_req(halt_step_req),
    .bkpt_hit     (bkpt_hit),
    .wpt_hit      (wpt_hit),
    .ext_probe    (ext_probe),
    .catch_hit    (catch_hit),
    .evt_vec      (evt_vec),
    .evt_any      (evt_any)
  );

  assign mon_on   = ctl_q[CTL_MON_EN];
  assign take     = event_taken(halt_en, mon_on);
  assign halt_set = halt_en & evt_any;
  assign pend_set = ~halt_en & mon_on & evt_any;
  assign clr_vec  = (wr_en && wr_sel) ? wr_data[NV-1:0] : '0;

  dcu_ctrl_reg #(.W(W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctl  (wr_en & ~wr_sel),
    .wr_data (wr_data),
    .pend_set(pend_set),
    .ctl_q   (ctl_q)
  );

  dcu_status_reg #(.NV(NV)) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_vec (evt_vec),
    .take    (take),
    .clr_vec (clr_vec),
    .status_q(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_req <= 1'b0;
    else        halt_req <= halt_set;
  end

  assign rd_data     = rd_sel ? {{(W-NV){1'b0}}, status_q} : ctl_q;
  assign mon_pend    = ctl_q[CTL_MON_PEND];
  assign mon_step_en = ctl_q[CTL_MON_STEP];
  assign trace_en    = ctl_q[CTL_TRACE];

  AST_HALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) halt_req |-> $past(halt_en)); // R5
  AST_HALT_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n) (halt_en && evt_any) |=> halt_req); // R4
  AST_CATCH_RECORDED: assert property (@(posedge clk) disable iff (!rst_n) (halt_en && catch_hit) |=> (halt_req && status_q[EV_VCATCH])); // R3
  AST_MON_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) (!halt_en && mon_on && evt_any) |=> (mon_pend && !halt_req)); // R6
endmodule

// File: tb/dbg_catch_unit_bench.sv
`timescale 1ns/1ps
module dbg_catch_unit_bench;
  localparam logic [31:0] MASK = 32'h010F_07F1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_en = 1'b0;
  logic [7:0]  exc_strobe = '0;
  logic        halt_step_req = 1'b0, bkpt_hit = 1'b0, wpt_hit = 1'b0, ext_probe = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        halt_req, mon_pend, mon_step_en, trace_en;

  int total = 0;
  int bad = 0;
  logic [31:0] m_ctl = '0;
  logic [4:0]  m_st = '0;
  logic        m_halt = 1'b0;

  always #10 clk = ~clk;

  dbg_catch_unit u_dbg_catch_unit (
    .clk(clk), .rst_n(rst_n), .halt_en(halt_en), .exc_strobe(exc_strobe),
    .halt_step_req(halt_step_req), .bkpt_hit(bkpt_hit), .wpt_hit(wpt_hit),
    .ext_probe(ext_probe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .halt_req(halt_req), .mon_pend(mon_pend),
    .mon_step_en(mon_step_en), .trace_en(trace_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // catch enables as listed in R3: strobe 0 -> bit 0, strobe i -> bit i+3
  function automatic logic [7:0] cen(input logic [31:0] c);
    return {c[10:4], c[0]};
  endfunction

  function automatic logic [4:0] events(input logic [31:0] c, input logic [7:0] ex,
                                        input logic hs, bk, wp, ep);
    return {ep, |(ex & cen(c)), wp, bk, hs};
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " R3/R4/R5 halt_req"}, {31'b0, halt_req}, {31'b0, m_halt});
    chk({tag, " R6/R10 mon_pend"}, {31'b0, mon_pend}, {31'b0, m_ctl[17]});
    chk({tag, " R11 mon_step_en"}, {31'b0, mon_step_en}, {31'b0, m_ctl[18]});
    chk({tag, " R11 trace_en"}, {31'b0, trace_en}, {31'b0, m_ctl[24]});
    rd_sel = 1'b0; #1;
    chk({tag, " R2 control read"}, rd_data, m_ctl);
    rd_sel = 1'b1; #1;
    chk({tag, " R8/R9 status read"}, rd_data, {27'b0, m_st});
  endtask

  // one clock with given stimulus; model advanced per requirements
  task automatic cyc(input string tag, input logic hen, input logic [7:0] ex,
                     input logic hs, bk, wp, ep,
                     input logic we, ws, input logic [31:0] wd);
    logic [4:0] ev, clr;
    logic take;
    logic [31:0] n_ctl;
    @(negedge clk);
    halt_en = hen; exc_strobe = ex; halt_step_req = hs; bkpt_hit = bk;
    wpt_hit = wp; ext_probe = ep; wr_en = we; wr_sel = ws; wr_data = wd;
    ev    = events(m_ctl, ex, hs, bk, wp, ep);
    take  = hen | m_ctl[16];
    clr   = (we && ws) ? wd[4:0] : 5'b0;
    n_ctl = (we && !ws) ? (wd & MASK) : m_ctl;
    if (!hen && m_ctl[16] && (|ev)) n_ctl[17] = 1'b1;
    @(posedge clk);
    m_halt = hen & (|ev);
    m_st   = (m_st & ~clr) | (take ? ev : 5'b0);
    m_ctl  = n_ctl;
    #1;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic wctl(input string tag, input logic [31:0] d);
    cyc(tag, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, d);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1; check_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    #1; check_all("R1 after release");

    // R2: all-ones write keeps only implemented bits
    wctl("R2 mask", 32'hFFFF_FFFF);
    chk("R2 mask value", m_ctl, MASK);
    wctl("R2 clear", 32'h0);

    // R3: each fault class mapped to its own enable
    for (int i = 0; i < 8; i++) begin
      int pos;
      pos = (i == 0) ? 0 : i + 3;
      wctl("R3 enable", 32'h1 << pos);
      cyc("R3 caught", 1'b1, 8'h1 << i, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
      chk("R3 vcatch flag", {27'b0, m_st}, 32'h8);
      cyc("R3 clear", 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1F);
      // a different strobe is not enabled: no effect
      cyc("R3 not caught", 1'b1, 8'h1 << ((i + 1) % 8), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
      chk("R3 no halt", {31'b0, halt_req}, 32'h0);
    end
    wctl("R3 off", 32'h0);

    // R4: individual event sources with halting on
    cyc("R4 step", 1'b1, 8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R4 bkpt", 1'b1, 8'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R4 wpt", 1'b1, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R4 ext", 1'b1, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R4 flags", {27'b0, m_st}, 32'h17);
    // R8: partial clear, set beats clear on bit 1
    cyc("R8 clr vs set", 1'b1, 8'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h03);
    chk("R8 result", {27'b0, m_st}, 32'h16);
    cyc("R8 clear all", 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1F);

    // R7: neither halting nor monitor
    cyc("R7 ignored", 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R7 status zero", {27'b0, m_st}, 32'h0);

    // R6: monitor routing, R9 simultaneous, R10 write vs event
    wctl("R6 mon on", 32'h0001_0401);
    cyc("R6 R9 mon event", 1'b0, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R9 flags", {27'b0, m_st}, 32'h0E);
    wctl("R10 clear pend", 32'h0001_0000);
    cyc("R10 event beats write", 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0001_0000);
    chk("R10 pend kept", {31'b0, mon_pend}, 32'h1);
    // R11: semaphore only reads back
    wctl("R11 sema", 32'h0008_0000);
    wctl("R11 step trace", 32'h0104_0000);
    idle("R11 idle");

    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r, d;
      logic [7:0] ex;
      r  = $urandom;
      ex = (r[3:0] == 0) ? 8'($urandom) : 8'h0;
      d  = $urandom;
      cyc("rand R3/R4/R6/R7/R8/R9", r[4], ex, r[5] & r[6], r[7] & r[8], r[9] & r[10],
          r[11] & r[12], r[15:13] == 0, r[16], d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule